// File: doc/BRIEF.md
# Ciphertext Unpacker with Decompression

The block converts a stored ciphertext into polynomial coefficients modulo q = 3329. It fetches ciphertext bytes one at a time, in ascending address order, from a byte memory whose read data returns one cycle after the request. The bits of each byte are appended least-significant bit first to a bit buffer. Fixed-width symbols are then taken from the low end of that buffer.

Each symbol passes through decompression, and the 12-bit result goes to a coefficient write port together with a destination slot and an index. The ciphertext has two sections. The first section holds K polynomials with a wide symbol width. The second section holds one polynomial with a narrow symbol width and goes to a dedicated slot.

A single-cycle start request selects K (2, 3 or 4) and begins a run. A one-cycle done pulse marks the end of the run.

Top module: `cipher_unpack`

## Requirements
- R1: After reset, busy_o, done_o, rd_en_o and cw_en_o are all low.
- R2: K=2 and K=3 use first-section width 10 and second-section width 4. K=4 uses widths 11 and 5. A run reads exactly 32*(du*K+dv) bytes (768, 1088 or 1568) at addresses 0 upward, each address once, in ascending order.
- R3: Bit b of byte a is stream bit 8a+b. Symbol n of a section is made of that section's stream bits n*d to n*d+d-1, with the lowest bit as the symbol's bit 0.
- R4: A symbol y of width d is written as floor((3329*y + 2^(d-1)) / 2^d), and every written value is below 3329.
- R5: First-section polynomial i (0 to K-1) is written to slot i, with indices 0 to 255 in ascending order. The polynomials come in ascending order of i.
- R6: The second-section polynomial is written to slot 4. Its bit stream starts at byte 32*du*K with an empty buffer.
- R7: A byte is appended to the buffer exactly one cycle after it is requested. The buffer never holds more than 18 bits, and it never supplies a symbol with fewer valid bits than the symbol width.
- R8: done_o is high for exactly one cycle, in the cycle after the final coefficient write, and busy_o is low from that cycle on.
- R9: A start request while busy_o is high is ignored; the current run continues unchanged.
- R10: A start request with a K outside {2,3,4} is ignored: busy_o stays low and no byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| rank_i | input | 3 | K, the number of first-section polynomials |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| rd_en_o | output | 1 | Byte read request |
| rd_addr_o | output | 11 | Byte read address |
| rd_data_i | input | 8 | Byte read data, valid one cycle after the request |
| cw_en_o | output | 1 | Coefficient write strobe |
| cw_slot_o | output | 3 | Destination polynomial slot |
| cw_idx_o | output | 8 | Coefficient index within the polynomial |
| cw_data_o | output | 12 | Decompressed coefficient |

## Verification
In one cycle the buffer can both take in a returned byte and give up a symbol. The new byte must then land just above the bits that remain after the pop, not above the old fill level.

Steady streaming with both symbol widths makes this coincidence happen many times in every run. Patterned ciphertext, all-ones and all-zeros inputs are used. The bench rebuilds every expected coefficient from stream bit positions and compares each write's value, slot and index. Any misplaced byte therefore shows up as a wrong coefficient in that position.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} cu_state_e;

  function automatic logic rank_ok(logic [2:0] k);
    return (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
  endfunction

  function automatic logic [3:0] du_of(logic [2:0] k);
    return (k == 3'd4) ? 4'd11 : 4'd10;
  endfunction

  function automatic logic [3:0] dv_of(logic [2:0] k);
    return (k == 3'd4) ? 4'd5 : 4'd4;
  endfunction
endpackage

// File: rtl/cu_bitbuf.sv
module cu_bitbuf #(
  parameter int MAX_D = 11,
  localparam int BUF_W = MAX_D + 7,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [7:0]       push_byte_i,
  input  logic             pop_i,
  input  logic [3:0]       width_i,
  output logic [MAX_D-1:0] sym_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [BUF_W-1:0] bits_q, bits_d, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [MAX_D-1:0] mask;

  always_comb begin
    shifted = pop_i ? (bits_q >> width_i) : bits_q;
    base    = cnt_q - (pop_i ? CNT_W'(width_i) : '0);
    bits_d  = shifted;
    cnt_d   = base;
    if (push_i) begin
      // new byte lands above what survives this cycle's pop
      bits_d = shifted | (BUF_W'(push_byte_i) << base);
      cnt_d  = base + CNT_W'(8);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mask  = (MAX_D'(1) << width_i) - MAX_D'(1);
  assign sym_o = bits_q[MAX_D-1:0] & mask;
  assign cnt_o = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_W));
  p_pop_has_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q >= CNT_W'(width_i)));
endmodule

// File: rtl/cu_decomp.sv
module cu_decomp #(
  parameter int Q      = 3329,
  parameter int MAX_D  = 11,
  parameter int COEF_W = 12,
  localparam int PW    = MAX_D + COEF_W
) (
  input  logic [MAX_D-1:0]  sym_i,
  input  logic [3:0]        d_i,
  output logic [COEF_W-1:0] coef_o
);
  logic [PW-1:0] prod, half, sum;

  always_comb begin
    prod   = PW'(Q) * PW'(sym_i);
    half   = PW'(1) << (d_i - 4'd1);
    sum    = prod + half;
    coef_o = COEF_W'(sum >> d_i);
  end
endmodule

// File: rtl/cipher_unpack.sv
module cipher_unpack
  import cu_pkg::*;
#(
  parameter int Q      = 3329,
  parameter int NCOEF  = 256,
  parameter int ADDR_W = 11,
  parameter int SLOT_W = 3,
  parameter int V_SLOT = 4,
  parameter int MAX_D  = 11,
  parameter int COEF_W = 12,
  localparam int IDX_W = $clog2(NCOEF),
  localparam int BUF_W = MAX_D + 7,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        rank_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              cw_en_o,
  output logic [SLOT_W-1:0] cw_slot_o,
  output logic [IDX_W-1:0]  cw_idx_o,
  output logic [COEF_W-1:0] cw_data_o
);
  cu_state_e         st_q;
  logic              sec_q, rd_pend_q, done_q;
  logic [2:0]        k_q, poly_q;
  logic [3:0]        du_q, dv_q, width;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] left_q, addr_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    room;
  logic [MAX_D-1:0]  sym;
  logic [COEF_W-1:0] coef;
  logic              accept, pop, last_idx, sec_switch, final_pop, clr;

  assign accept     = (st_q == ST_IDLE) && start_i && rank_ok(rank_i);
  assign width      = sec_q ? dv_q : du_q;
  assign pop        = (st_q == ST_RUN) && (cnt >= CNT_W'(width));
  assign last_idx   = (idx_q == IDX_W'(NCOEF - 1));
  assign sec_switch = pop && !sec_q && last_idx && (poly_q == k_q - 3'd1);
  assign final_pop  = pop && sec_q && last_idx;
  assign clr        = accept || sec_switch;

  // fill level next cycle before any new request lands
  assign room = {1'b0, cnt} - (pop ? (CNT_W+1)'(width) : '0)
              + (rd_pend_q ? (CNT_W+1)'(8) : '0);
  assign rd_en_o = (st_q == ST_RUN) && (left_q != '0) && !sec_switch
                 && (room + (CNT_W+1)'(8) <= (CNT_W+1)'(BUF_W));
  assign rd_addr_o = addr_q;

  cu_bitbuf #(.MAX_D(MAX_D)) i_bitbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .push_i     (rd_pend_q),
    .push_byte_i(rd_data_i),
    .pop_i      (pop),
    .width_i    (width),
    .sym_o      (sym),
    .cnt_o      (cnt)
  );

  cu_decomp #(.Q(Q), .MAX_D(MAX_D), .COEF_W(COEF_W)) i_decomp (
    .sym_i (sym),
    .d_i   (width),
    .coef_o(coef)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sec_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
      k_q       <= 3'd2;
      poly_q    <= '0;
      du_q      <= 4'd10;
      dv_q      <= 4'd4;
      idx_q     <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      cw_en_o   <= 1'b0;
      cw_slot_o <= '0;
      cw_idx_o  <= '0;
      cw_data_o <= '0;
    end else begin
      rd_pend_q <= rd_en_o;
      cw_en_o   <= 1'b0;
      done_q    <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_RUN;
          k_q    <= rank_i;
          du_q   <= du_of(rank_i);
          dv_q   <= dv_of(rank_i);
          sec_q  <= 1'b0;
          poly_q <= '0;
          idx_q  <= '0;
          addr_q <= '0;
          left_q <= (ADDR_W'(du_of(rank_i)) * ADDR_W'(rank_i)) << 5;
        end
        ST_RUN: begin
          if (rd_en_o) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - ADDR_W'(1);
          end
          if (pop) begin
            idx_q     <= idx_q + IDX_W'(1);
            cw_en_o   <= 1'b1;
            cw_slot_o <= sec_q ? SLOT_W'(V_SLOT) : SLOT_W'(poly_q);
            cw_idx_o  <= idx_q;
            cw_data_o <= coef;
            if (sec_switch) begin
              sec_q  <= 1'b1;
              left_q <= ADDR_W'(dv_q) << 5;
            end else if (last_idx && !sec_q) begin
              poly_q <= poly_q + 3'd1;
            end
            if (final_pop) st_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  p_below_q_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_en_o |-> (cw_data_o < COEF_W'(Q)));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cw_en_o) && !busy_o));
  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(k_q));
  p_no_stray_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_switch |-> !rd_pend_q);
  p_idle_no_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_en_o);
endmodule

// File: tb/test_cipher_unpack.sv
module test_cipher_unpack;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3329;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  rank_i = 3'd2;
  logic        busy_o, done_o, rd_en_o, cw_en_o;
  logic [10:0] rd_addr_o;
  logic [7:0]  rd_data_i = 8'h00;
  logic [2:0]  cw_slot_o;
  logic [7:0]  cw_idx_o;
  logic [11:0] cw_data_o;

  cipher_unpack i_cipher_unpack (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rank_i(rank_i),
    .busy_o(busy_o), .done_o(done_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .cw_en_o(cw_en_o), .cw_slot_o(cw_slot_o),
    .cw_idx_o(cw_idx_o), .cw_data_o(cw_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int cur_k = 2, cur_seed = 0, w_cnt = 0, exp_addr = 0, n_reads = 0;
  bit pend_done = 0, done_seen = 0;

  function automatic logic [7:0] pat(int s, int a);
    if (s == 1) return 8'hFF;
    if (s == 2) return 8'h00;
    return 8'((a * 73 + s * 29) ^ ((a >> 2) * 151) ^ (a >> 5));
  endfunction

  function automatic int du_f(int k); return (k == 4) ? 11 : 10; endfunction
  function automatic int dv_f(int k); return (k == 4) ? 5 : 4; endfunction
  function automatic int n_bytes(int k); return 32 * (du_f(k) * k + dv_f(k)); endfunction

  // coefficient number w of a run, rebuilt from stream bit positions
  function automatic int exp_coef(int s, int k, int w);
    int d, pos, y, bp;
    if (w < k * 256) begin d = du_f(k); pos = w * d; end
    else begin d = dv_f(k); pos = k * 256 * du_f(k) + (w - k * 256) * d; end
    y = 0;
    for (int b = 0; b < d; b++) begin
      bp = pos + b;
      y = y | (((pat(s, bp >> 3) >> (bp & 7)) & 1) << b);
    end
    return (Q * y + (1 << (d - 1))) >> d;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // byte memory model, one cycle read latency
  always @(posedge clk) if (rd_en_o) rd_data_i <= pat(cur_seed, int'(rd_addr_o));

  // monitor sampling on the falling edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pend_done) begin
        chk(done_o == 1'b1, "R8 done after final write", int'(done_o), 1);
        chk(busy_o == 1'b0, "R8 busy low with done", int'(busy_o), 0);
        pend_done = 0;
        done_seen = 1;
      end else if (done_o) begin
        chk(1'b0, "R8 stray done", 1, 0);
      end
      if (rd_en_o) begin
        chk(int'(rd_addr_o) == exp_addr, "R2 read address", int'(rd_addr_o), exp_addr);
        exp_addr++;
        n_reads++;
      end
      if (cw_en_o) begin
        int es, ei, ev;
        es = (w_cnt < cur_k * 256) ? (w_cnt / 256) : 4;
        ei = w_cnt % 256;
        ev = exp_coef(cur_seed, cur_k, w_cnt);
        chk(int'(cw_slot_o) == es, (es == 4) ? "R6 slot" : "R5 slot", int'(cw_slot_o), es);
        chk(int'(cw_idx_o) == ei, "R5 index", int'(cw_idx_o), ei);
        chk(int'(cw_data_o) == ev, "R3 R4 coefficient", int'(cw_data_o), ev);
        chk(int'(cw_data_o) < Q, "R4 below q", int'(cw_data_o), Q - 1);
        w_cnt++;
        if (w_cnt == (cur_k + 1) * 256) pend_done = 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pulse_start(int k);
    @(posedge clk); #2;
    rank_i = 3'(k); start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic run(int k, int s, bit poke);
    int t;
    cur_k = k; cur_seed = s; w_cnt = 0; exp_addr = 0; n_reads = 0; done_seen = 0;
    pulse_start(k);
    @(negedge clk);
    chk(busy_o == 1'b1, "R2 run starts", int'(busy_o), 1);
    if (poke) begin
      repeat (100) @(posedge clk);
      #2; rank_i = 3'd4; start_i = 1'b1;   // R9: must be ignored
      @(posedge clk); #2; start_i = 1'b0;
    end
    t = 0;
    while (!done_seen && t < 20000) begin @(posedge clk); t++; end
    chk(done_seen, "R8 run finished", int'(done_seen), 1);
    @(negedge clk);
    chk(w_cnt == (k + 1) * 256, poke ? "R9 write count" : "R5 R6 write count", w_cnt, (k + 1) * 256);
    chk(n_reads == n_bytes(k), "R2 byte count", n_reads, n_bytes(k));
    chk(done_o == 1'b0, "R8 single cycle done", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !rd_en_o && !cw_en_o, "R1 reset state",
        int'({busy_o, done_o, rd_en_o, cw_en_o}), 0);
    #2 rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !cw_en_o, "R1 after release", int'({busy_o, cw_en_o}), 0);

    run(2, 7, 0);
    run(3, 11, 1);
    run(4, 5, 0);
    run(4, 1, 0);   // all ones: max symbol values
    run(2, 2, 0);   // all zeros
    run(3, 1, 0);

    // R10: out-of-range K
    n_reads = 0;
    pulse_start(5);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R10 K=5 ignored busy", int'(busy_o), 0);
    pulse_start(1);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R10 K=1 ignored busy", int'(busy_o), 0);
    chk(n_reads == 0, "R10 no reads", n_reads, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule